// File: doc/BRIEF.md
# Two-Source Vectored Interrupt Controller

This block chooses between two interrupt sources of a small 8-bit processor core, a USB event and a timer overflow, and turns the winner into a vector address with a call request. Each source has a latched request flag and an enable bit. A master enable gates both sources. The core signals instruction boundaries on `step_i`. At such a boundary the controller may enter an interrupt if the master enable is on, the source is enabled and flagged, and the core's stack has room. Entry clears the serviced flag and the master enable. The return-from-interrupt strobe turns the master enable back on. A plain return leaves it as it is.

Software reads and writes the control register, which holds the enables and the flags. It also reads and writes a USB status register. Resume and bus-reset detection arrive as single-cycle pulses. Each pulse sets its own status bit and also raises the USB request.

The arbiter is a two-state machine. In `ARB_WAIT` it watches the boundary strobe. The transition `WAIT->ISSUE` is taken at an eligible boundary. `ARB_ISSUE` drives the call and vector for one cycle and then always returns to `ARB_WAIT` by the transition `ISSUE->WAIT`.

Top module: `irq_vec_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `ctl_o`, `sts_o` and `vec_o` read 0 and `call_o` reads 0.
- R2: A control write replaces the register in one clock. The control register bits are: master enable at bit 0, USB enable at bit 1, timer enable at bit 2, USB flag at bit 4 and timer flag at bit 6. The other bits read 0.
- R3: A timer overflow pulse sets bit 6. A USB event, resume or reset pulse sets bit 4. Flags stay set whatever the enables are, until the interrupt is entered or software clears them.
- R4: Entry happens only at an edge where `step_i` is high, the master enable is on, the source enable and flag are both set, and `stack_full_i` is low.
- R5: The USB vector is 0x04 and the timer vector is 0x0C. When both sources are eligible at once, USB is taken.
- R6: Entry clears the serviced flag and the master enable at the sampling edge. `call_o` is high for exactly the following cycle, and `vec_o` holds the vector in that cycle. `vec_o` reads 0 at all other times.
- R7: `reti_i` sets the master enable. `ret_i` alone leaves it unchanged.
- R8: A resume pulse sets status bit 3. A bus-reset pulse sets status bit 0. Only a status write clears these bits.
- R9: A software write takes precedence over any hardware set, entry clear or `reti_i` in the same cycle.
- R10: If a source's flag is set by hardware in the same cycle that an entry for that source clears it, the flag ends up set.
- R11: A request that is latched in the same cycle as a boundary is not taken at that boundary. It is taken at the next eligible boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Instruction boundary (sampling point) |
| stack_full_i | input | 1 | Core stack has no free slot |
| ret_i | input | 1 | Plain return strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| usb_evt_i | input | 1 | Generic USB interrupt event pulse |
| usb_resume_i | input | 1 | USB resume detected pulse |
| usb_reset_i | input | 1 | USB bus reset detected pulse |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| sts_we_i | input | 1 | Status register write strobe |
| sts_wdata_i | input | 8 | Status register write data |
| ctl_o | output | 8 | Control register contents |
| sts_o | output | 8 | USB status register contents |
| call_o | output | 1 | Interrupt call request, one cycle |
| vec_o | output | 8 | Vector address during `call_o` |

## Verification
Two functions can land on the same flag in the same cycle: the clear done by an entry and a fresh hardware set of that flag. The bench provokes this by pulsing the timer overflow in the cycle of the boundary that takes the timer interrupt. It then expects `call_o` with vector 0x0C and the timer flag still reading 1 afterwards. A later boundary, after `reti_i`, must take the timer interrupt a second time. A second collision is a software write in the same cycle as flag-setting pulses. It is judged by the written value appearing unchanged in both registers.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    localparam int DATA_W     = 8;
    localparam int GIE_BIT    = 0;
    localparam int UEN_BIT    = 1;
    localparam int TEN_BIT    = 2;
    localparam int UFLAG_BIT  = 4;
    localparam int TFLAG_BIT  = 6;
    localparam int RESUME_BIT = 3;
    localparam int BUSRST_BIT = 0;

    typedef enum logic {
        ARB_WAIT  = 1'b0,
        ARB_ISSUE = 1'b1
    } arb_state_e;
endpackage

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
    import irq_vec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              usb_set_i,
    input  logic              tmr_set_i,
    input  logic              usb_take_i,
    input  logic              tmr_take_i,
    input  logic              reti_i,
    output logic              gie_o,
    output logic              usb_rdy_o,
    output logic              tmr_rdy_o,
    output logic [DATA_W-1:0] ctl_o
);
    logic gie_q, uen_q, ten_q, uflag_q, tflag_q;
    logic take;
    logic unused_wdata;

    assign take = usb_take_i | tmr_take_i;
    assign unused_wdata = ^{wdata_i[DATA_W-1], wdata_i[5], wdata_i[3]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q   <= 1'b0;
            uen_q   <= 1'b0;
            ten_q   <= 1'b0;
            uflag_q <= 1'b0;
            tflag_q <= 1'b0;
        end else if (we_i) begin
            gie_q   <= wdata_i[GIE_BIT];
            uen_q   <= wdata_i[UEN_BIT];
            ten_q   <= wdata_i[TEN_BIT];
            uflag_q <= wdata_i[UFLAG_BIT];
            tflag_q <= wdata_i[TFLAG_BIT];
        end else begin
            if (take)             gie_q <= 1'b0;
            else if (reti_i)      gie_q <= 1'b1;
            if (usb_set_i)        uflag_q <= 1'b1;
            else if (usb_take_i)  uflag_q <= 1'b0;
            if (tmr_set_i)        tflag_q <= 1'b1;
            else if (tmr_take_i)  tflag_q <= 1'b0;
        end
    end

    always_comb begin
        ctl_o            = '0;
        ctl_o[GIE_BIT]   = gie_q;
        ctl_o[UEN_BIT]   = uen_q;
        ctl_o[TEN_BIT]   = ten_q;
        ctl_o[UFLAG_BIT] = uflag_q;
        ctl_o[TFLAG_BIT] = tflag_q;
    end

    assign gie_o     = gie_q;
    assign usb_rdy_o = uen_q & uflag_q;
    assign tmr_rdy_o = ten_q & tflag_q;

    // R6
    entry_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !we_i) |=> !gie_q);
    // R7
    reti_sets_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && !take && !we_i) |=> gie_q);
    // R10
    tmr_set_beats_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_set_i && !we_i) |=> tflag_q);
endmodule

// File: rtl/irq_usb_status.sv
module irq_usb_status
    import irq_vec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              resume_i,
    input  logic              busrst_i,
    output logic [DATA_W-1:0] sts_o
);
    logic resume_q, busrst_q;
    logic unused_wdata;

    assign unused_wdata = ^{wdata_i[DATA_W-1:4], wdata_i[2:1]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resume_q <= 1'b0;
            busrst_q <= 1'b0;
        end else if (we_i) begin
            resume_q <= wdata_i[RESUME_BIT];
            busrst_q <= wdata_i[BUSRST_BIT];
        end else begin
            if (resume_i) resume_q <= 1'b1;
            if (busrst_i) busrst_q <= 1'b1;
        end
    end

    always_comb begin
        sts_o             = '0;
        sts_o[RESUME_BIT] = resume_q;
        sts_o[BUSRST_BIT] = busrst_q;
    end

    // R8
    busrst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busrst_q && !we_i) |=> busrst_q);
    // R8
    resume_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_i && !we_i) |=> resume_q);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_vec_pkg::*;
#(
    parameter int               VEC_W   = 8,
    parameter logic [VEC_W-1:0] USB_VEC = 'h04,
    parameter logic [VEC_W-1:0] TMR_VEC = 'h0C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             stack_full_i,
    input  logic             gie_i,
    input  logic             usb_rdy_i,
    input  logic             tmr_rdy_i,
    output logic             usb_take_o,
    output logic             tmr_take_o,
    output logic             call_o,
    output logic [VEC_W-1:0] vec_o
);
    arb_state_e       state_q, state_d;
    logic [VEC_W-1:0] vec_d, vec_q;

    always_comb begin
        state_d    = state_q;
        vec_d      = '0;
        usb_take_o = 1'b0;
        tmr_take_o = 1'b0;
        unique case (state_q)
            ARB_WAIT: begin
                if (step_i && gie_i && !stack_full_i && (usb_rdy_i || tmr_rdy_i)) begin
                    state_d = ARB_ISSUE;
                    if (usb_rdy_i) begin
                        usb_take_o = 1'b1;
                        vec_d      = USB_VEC;
                    end else begin
                        tmr_take_o = 1'b1;
                        vec_d      = TMR_VEC;
                    end
                end
            end
            ARB_ISSUE: state_d = ARB_WAIT;
            default:   state_d = ARB_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARB_WAIT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vec_q <= '0;
        else        vec_q <= vec_d;
    end

    assign call_o = (state_q == ARB_ISSUE);
    assign vec_o  = vec_q;

    // R4
    entry_needs_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        call_o |-> $past(step_i && !stack_full_i && gie_i));
    // R6
    call_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        call_o |=> !call_o);
    // R5
    usb_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_o && $past(usb_rdy_i)) |-> (vec_o == USB_VEC));
    // R6
    vec_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !call_o |-> (vec_o == '0));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_vec_pkg::*;
#(
    parameter int               VEC_W   = 8,
    parameter logic [VEC_W-1:0] USB_VEC = 'h04,
    parameter logic [VEC_W-1:0] TMR_VEC = 'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              stack_full_i,
    input  logic              ret_i,
    input  logic              reti_i,
    input  logic              usb_evt_i,
    input  logic              usb_resume_i,
    input  logic              usb_reset_i,
    input  logic              tmr_ovf_i,
    input  logic              ctl_we_i,
    input  logic [DATA_W-1:0] ctl_wdata_i,
    input  logic              sts_we_i,
    input  logic [DATA_W-1:0] sts_wdata_i,
    output logic [DATA_W-1:0] ctl_o,
    output logic [DATA_W-1:0] sts_o,
    output logic              call_o,
    output logic [VEC_W-1:0]  vec_o
);
    logic gie, usb_rdy, tmr_rdy, usb_take, tmr_take, usb_set;

    assign usb_set = usb_evt_i | usb_resume_i | usb_reset_i;

    irq_ctl_regs u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (ctl_we_i),
        .wdata_i    (ctl_wdata_i),
        .usb_set_i  (usb_set),
        .tmr_set_i  (tmr_ovf_i),
        .usb_take_i (usb_take),
        .tmr_take_i (tmr_take),
        .reti_i     (reti_i),
        .gie_o      (gie),
        .usb_rdy_o  (usb_rdy),
        .tmr_rdy_o  (tmr_rdy),
        .ctl_o      (ctl_o)
    );

    irq_usb_status u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (sts_we_i),
        .wdata_i  (sts_wdata_i),
        .resume_i (usb_resume_i),
        .busrst_i (usb_reset_i),
        .sts_o    (sts_o)
    );

    irq_arbiter #(
        .VEC_W   (VEC_W),
        .USB_VEC (USB_VEC),
        .TMR_VEC (TMR_VEC)
    ) u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_i       (step_i),
        .stack_full_i (stack_full_i),
        .gie_i        (gie),
        .usb_rdy_i    (usb_rdy),
        .tmr_rdy_i    (tmr_rdy),
        .usb_take_o   (usb_take),
        .tmr_take_o   (tmr_take),
        .call_o       (call_o),
        .vec_o        (vec_o)
    );

    // R7
    ret_keeps_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !reti_i && !ctl_we_i && !usb_take && !tmr_take) |=> $stable(ctl_o[GIE_BIT]));
    // R9
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we_i |=> (ctl_o[TFLAG_BIT] == $past(ctl_wdata_i[TFLAG_BIT])));
endmodule

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n, step_i, stack_full_i, ret_i, reti_i;
    logic       usb_evt_i, usb_resume_i, usb_reset_i, tmr_ovf_i;
    logic       ctl_we_i, sts_we_i;
    logic [7:0] ctl_wdata_i, sts_wdata_i, ctl_o, sts_o, vec_o;
    logic       call_o;

    int n_chk  = 0;
    int n_fail = 0;

    irq_vec_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .stack_full_i(stack_full_i),
        .ret_i(ret_i), .reti_i(reti_i), .usb_evt_i(usb_evt_i),
        .usb_resume_i(usb_resume_i), .usb_reset_i(usb_reset_i),
        .tmr_ovf_i(tmr_ovf_i), .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i),
        .sts_we_i(sts_we_i), .sts_wdata_i(sts_wdata_i), .ctl_o(ctl_o),
        .sts_o(sts_o), .call_o(call_o), .vec_o(vec_o)
    );

    // Row: req[54:51] cwe[50] cwd[49:42] swe[41] swd[40:33]
    // ev[32:25] = {usb,resume,busrst,tmr,step,full,reti,ret}
    // exp ctl[24:17] sts[16:9] call[8] vec[7:0]
    localparam int NROW = 21;
    localparam logic [54:0] TBL [NROW] = '{
        {4'd2,  1'b1, 8'h07, 1'b0, 8'h00, 8'h00, 8'h07, 8'h00, 1'b0, 8'h00}, // R2 enable all
        {4'd3,  1'b0, 8'h00, 1'b0, 8'h00, 8'h10, 8'h47, 8'h00, 1'b0, 8'h00}, // R3 timer flag
        {4'd5,  1'b0, 8'h00, 1'b0, 8'h00, 8'h08, 8'h06, 8'h00, 1'b1, 8'h0C}, // R5 timer vector
        {4'd6,  1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 8'h06, 8'h00, 1'b0, 8'h00}, // R6 one cycle
        {4'd3,  1'b0, 8'h00, 1'b0, 8'h00, 8'h80, 8'h16, 8'h00, 1'b0, 8'h00}, // R3 usb flag
        {4'd4,  1'b0, 8'h00, 1'b0, 8'h00, 8'h08, 8'h16, 8'h00, 1'b0, 8'h00}, // R4 gie off
        {4'd7,  1'b0, 8'h00, 1'b0, 8'h00, 8'h01, 8'h16, 8'h00, 1'b0, 8'h00}, // R7 plain ret
        {4'd7,  1'b0, 8'h00, 1'b0, 8'h00, 8'h02, 8'h17, 8'h00, 1'b0, 8'h00}, // R7 reti
        {4'd4,  1'b0, 8'h00, 1'b0, 8'h00, 8'h0C, 8'h17, 8'h00, 1'b0, 8'h00}, // R4 stack full
        {4'd3,  1'b0, 8'h00, 1'b0, 8'h00, 8'h10, 8'h57, 8'h00, 1'b0, 8'h00}, // R3 both pending
        {4'd5,  1'b0, 8'h00, 1'b0, 8'h00, 8'h08, 8'h46, 8'h00, 1'b1, 8'h04}, // R5 usb wins
        {4'd7,  1'b0, 8'h00, 1'b0, 8'h00, 8'h02, 8'h47, 8'h00, 1'b0, 8'h00}, // R7 reti
        {4'd6,  1'b0, 8'h00, 1'b0, 8'h00, 8'h08, 8'h06, 8'h00, 1'b1, 8'h0C}, // R6 timer entry
        {4'd9,  1'b1, 8'h03, 1'b0, 8'h00, 8'h02, 8'h03, 8'h00, 1'b0, 8'h00}, // R9 write + reti
        {4'd3,  1'b0, 8'h00, 1'b0, 8'h00, 8'h10, 8'h43, 8'h00, 1'b0, 8'h00}, // R3 flag w/o enable
        {4'd4,  1'b0, 8'h00, 1'b0, 8'h00, 8'h08, 8'h43, 8'h00, 1'b0, 8'h00}, // R4 source off
        {4'd8,  1'b0, 8'h00, 1'b0, 8'h00, 8'h40, 8'h53, 8'h08, 1'b0, 8'h00}, // R8 resume
        {4'd5,  1'b0, 8'h00, 1'b0, 8'h00, 8'h08, 8'h42, 8'h08, 1'b1, 8'h04}, // R5 usb entry
        {4'd8,  1'b0, 8'h00, 1'b0, 8'h00, 8'h20, 8'h52, 8'h09, 1'b0, 8'h00}, // R8 bus reset
        {4'd9,  1'b1, 8'h00, 1'b1, 8'h00, 8'h30, 8'h00, 8'h00, 1'b0, 8'h00}, // R9 write wins
        {4'd9,  1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00}  // R9 stays clear
    };

    task automatic chk(input string req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        {ctl_we_i, sts_we_i, step_i, stack_full_i, ret_i, reti_i} = '0;
        {usb_evt_i, usb_resume_i, usb_reset_i, tmr_ovf_i} = '0;
        ctl_wdata_i = '0;
        sts_wdata_i = '0;
    endtask

    task automatic run_row(input logic [54:0] r);
        string req;
        ctl_we_i    = r[50];
        ctl_wdata_i = r[49:42];
        sts_we_i    = r[41];
        sts_wdata_i = r[40:33];
        {usb_evt_i, usb_resume_i, usb_reset_i, tmr_ovf_i,
         step_i, stack_full_i, reti_i, ret_i} = r[32:25];
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        req = $sformatf("R%0d", r[54:51]);
        chk(req, "ctl", ctl_o, r[24:17]);
        chk(req, "sts", sts_o, r[16:9]);
        chk(req, "call", {7'd0, call_o}, {7'd0, r[8]});
        chk(req, "vec", vec_o, r[7:0]);
    endtask

    initial begin
        #(4 * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1", "ctl", ctl_o, 8'h00);
        chk("R1", "call", {7'd0, call_o}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "sts", sts_o, 8'h00);
        chk("R1", "vec", vec_o, 8'h00);

        for (int i = 0; i < NROW; i++) run_row(TBL[i]);

        // R10: timer pulse collides with timer entry
        run_row({4'd10, 1'b1, 8'h07, 1'b0, 8'h00, 8'h00, 8'h07, 8'h00, 1'b0, 8'h00});
        run_row({4'd10, 1'b0, 8'h00, 1'b0, 8'h00, 8'h10, 8'h47, 8'h00, 1'b0, 8'h00});
        run_row({4'd10, 1'b0, 8'h00, 1'b0, 8'h00, 8'h18, 8'h46, 8'h00, 1'b1, 8'h0C});
        run_row({4'd10, 1'b0, 8'h00, 1'b0, 8'h00, 8'h02, 8'h47, 8'h00, 1'b0, 8'h00});
        run_row({4'd10, 1'b0, 8'h00, 1'b0, 8'h00, 8'h08, 8'h06, 8'h00, 1'b1, 8'h0C});

        // R11: request latched at a boundary waits for the next one
        run_row({4'd11, 1'b0, 8'h00, 1'b0, 8'h00, 8'h02, 8'h07, 8'h00, 1'b0, 8'h00});
        run_row({4'd11, 1'b0, 8'h00, 1'b0, 8'h00, 8'h88, 8'h17, 8'h00, 1'b0, 8'h00});
        run_row({4'd11, 1'b0, 8'h00, 1'b0, 8'h00, 8'h08, 8'h06, 8'h00, 1'b1, 8'h04});

        // R1: reset in mid-run
        run_row({4'd1, 1'b0, 8'h00, 1'b0, 8'h00, 8'h70, 8'h56, 8'h09, 1'b0, 8'h00});
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1", "ctl", ctl_o, 8'h00);
        chk("R1", "sts", sts_o, 8'h00);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule